// File: doc/BRIEF.md
# Burst Write DMA Master with Host Register Port

The block copies a run of data words into host memory on its own. Host software first programs a start address and a word count through a small register port. It then writes a start bit. From that point the engine needs no further help. It asks for the shared bus, waits for the grant and presents the start address for one cycle. It then streams one data word per clock to consecutive word addresses.

The data words come from a local source. The source shows the word at its head on `src_data`, and the engine consumes that word with a one-cycle `src_pop` pulse whenever the bus accepts it. The target may refuse a word by raising `bus_stop`. In that case the engine gives up the bus for one cycle, asks for it again, and carries on from the refused word. When the last word has been accepted, the engine releases the bus and raises `irq`. `irq` stays high until software clears it through the register port.

The register port takes single accesses. `reg_xfer` marks an access, `reg_dir` selects a write (1) or a read (0), and `reg_addr` picks the register. Read data appears on `reg_rdata` in the clock after the read.

Top module: `burst_dma_wr`

## Requirements
- R1: After reset `bus_req`, `bus_start`, `bus_valid` and `irq` are 0, and the status register reads 0.
- R2: Register offsets are 0 = start word address, 1 = word count, 2 = control/status, 3 = current word address. A value written to offset 0 or 1 is returned on `reg_rdata` in the cycle after a read of that offset.
- R3: A write to offset 2 with bit 0 set, made while idle with a non-zero count, raises `bus_req` in the next cycle, and status bit 0 (busy) reads 1 until the transfer ends.
- R4: Each time the grant is seen while requesting, `bus_start` is high for exactly one cycle and carries the word address of the next word still to be sent. `bus_valid` rises in the following cycle.
- R5: A word is accepted in every cycle where `bus_valid` is 1 and `bus_stop` is 0. `bus_data` is then the word at `src_data`, `src_pop` pulses once, and the address advances by one. Exactly the programmed count of words is accepted, and the current address then reads start + count.
- R6: A word presented while `bus_stop` is 1 is not accepted. In the next cycle `bus_req` and `bus_valid` are 0, the remaining count is unchanged, and one cycle later `bus_req` is raised again.
- R7: `bus_req` is 0 in the cycle after the last word is accepted. `bus_start` and `bus_valid` are only ever 1 while `bus_gnt` is 1.
- R8: In the cycle after the last word is accepted, `irq` is 1. Status then reads busy = 0, bit 1 (done) = 1, and bits 31:16 (remaining count) = 0.
- R9: A write to offset 2 with bit 1 set clears `irq` and the done bit.
- R10: A start write made while a transfer is in progress has no effect. The running transfer still sends exactly its original count.
- R11: A start write with a count of 0 raises `irq` in the next cycle, and `bus_req` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_xfer | input | 1 | Register access strobe |
| reg_dir | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 2 | Register offset |
| reg_wdata | input | DW | Register write data |
| reg_rdata | output | DW | Register read data, valid one cycle after the read |
| src_data | input | DW | Word at the head of the local source |
| src_pop | output | 1 | Head word consumed this cycle |
| bus_req | output | 1 | Bus request |
| bus_gnt | input | 1 | Bus grant |
| bus_start | output | 1 | Address phase marker |
| bus_addr | output | AW | Word address during the address phase |
| bus_valid | output | 1 | Data word presented |
| bus_data | output | DW | Data word |
| bus_stop | input | 1 | Target refuses the word and ends the burst |
| irq | output | 1 | Transfer complete |

## Verification
The grant checks assume an arbiter that raises `bus_gnt` only while `bus_req` is high and keeps it high until the request falls. The stimulus model follows that rule. It grants after a programmable delay and drops the grant in the first cycle the request is low. `bus_stop` is assumed to matter only while `bus_valid` is high. The stimulus raises it for a single presented word per transfer, and never outside a data phase. The source is assumed to always have a word ready, and the model updates `src_data` right after each accepted word.

// File: rtl/bdma_pkg.sv
package bdma_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_REQ, ST_ADDR, ST_DATA, ST_BACKOFF
  } mst_state_t;

  localparam logic [1:0] OFS_START = 2'd0;
  localparam logic [1:0] OFS_LEN   = 2'd1;
  localparam logic [1:0] OFS_CTRL  = 2'd2;
  localparam logic [1:0] OFS_CUR   = 2'd3;

  localparam int STAT_SHIFT = 16;
endpackage

// File: rtl/bdma_regs.sv
module bdma_regs
  import bdma_pkg::*;
#(
  parameter int DW = 32,
  parameter int AW = 32,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          reg_xfer,
  input  logic          reg_dir,
  input  logic [1:0]    reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  input  logic          busy,
  input  logic          done,
  input  logic [CW-1:0] remain,
  input  logic [AW-1:0] cur_addr,
  output logic [AW-1:0] cfg_start,
  output logic [CW-1:0] cfg_len,
  output logic          go,
  output logic          clr
);
  logic          wr_en;
  logic          rd_en;
  logic [DW-1:0] stat_word;
  logic [DW-1:0] rd_mux;

  assign wr_en = reg_xfer & reg_dir;
  assign rd_en = reg_xfer & ~reg_dir;
  assign go    = wr_en && (reg_addr == OFS_CTRL) && reg_wdata[0];
  assign clr   = wr_en && (reg_addr == OFS_CTRL) && reg_wdata[1];

  always_comb begin
    stat_word = '0;
    stat_word[0] = busy;
    stat_word[1] = done;
    stat_word[STAT_SHIFT +: CW] = remain;
  end

  always_comb begin
    case (reg_addr)
      OFS_START: rd_mux = DW'(cfg_start);
      OFS_LEN:   rd_mux = DW'(cfg_len);
      OFS_CTRL:  rd_mux = stat_word;
      default:   rd_mux = DW'(cur_addr);
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_start <= '0;
      cfg_len   <= '0;
      reg_rdata <= '0;
    end else begin
      if (wr_en && reg_addr == OFS_START) cfg_start <= reg_wdata[AW-1:0];
      if (wr_en && reg_addr == OFS_LEN)   cfg_len   <= reg_wdata[CW-1:0];
      if (rd_en) reg_rdata <= rd_mux;
    end
  end
endmodule

// File: rtl/bdma_master.sv
module bdma_master
  import bdma_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          go,
  input  logic          clr,
  input  logic [AW-1:0] cfg_start,
  input  logic [CW-1:0] cfg_len,
  input  logic          bus_gnt,
  input  logic          bus_stop,
  output logic          bus_req,
  output logic          bus_start,
  output logic [AW-1:0] bus_addr,
  output logic          bus_valid,
  output logic          src_pop,
  output logic          busy,
  output logic          done,
  output logic [CW-1:0] remain,
  output logic [AW-1:0] cur_addr
);
  mst_state_t state;
  logic       accept;
  logic       last_word;

  assign accept    = bus_valid & ~bus_stop;
  assign last_word = (remain == CW'(1));
  assign src_pop   = accept;
  assign busy      = (state != ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      bus_req   <= 1'b0;
      bus_start <= 1'b0;
      bus_valid <= 1'b0;
      bus_addr  <= '0;
      cur_addr  <= '0;
      remain    <= '0;
      done      <= 1'b0;
    end else begin
      bus_start <= 1'b0;
      if (clr) done <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (go) begin
            if (cfg_len == '0) begin
              done <= 1'b1;
            end else begin
              state    <= ST_REQ;
              bus_req  <= 1'b1;
              cur_addr <= cfg_start;
              remain   <= cfg_len;
              done     <= 1'b0;
            end
          end
        end
        ST_REQ: begin
          if (bus_gnt) begin
            state     <= ST_ADDR;
            bus_start <= 1'b1;
            bus_addr  <= cur_addr;
          end
        end
        ST_ADDR: begin
          state     <= ST_DATA;
          bus_valid <= 1'b1;
        end
        ST_DATA: begin
          if (bus_stop) begin
            state     <= ST_BACKOFF;
            bus_valid <= 1'b0;
            bus_req   <= 1'b0;
          end else begin
            cur_addr <= cur_addr + AW'(1);
            remain   <= remain - CW'(1);
            if (last_word) begin
              state     <= ST_IDLE;
              bus_valid <= 1'b0;
              bus_req   <= 1'b0;
              done      <= 1'b1;
            end
          end
        end
        ST_BACKOFF: begin
          state   <= ST_REQ;
          bus_req <= 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/burst_dma_wr.sv
module burst_dma_wr
  import bdma_pkg::*;
#(
  parameter int DW = 32,
  parameter int AW = 32,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          reg_xfer,
  input  logic          reg_dir,
  input  logic [1:0]    reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  input  logic [DW-1:0] src_data,
  output logic          src_pop,
  output logic          bus_req,
  input  logic          bus_gnt,
  output logic          bus_start,
  output logic [AW-1:0] bus_addr,
  output logic          bus_valid,
  output logic [DW-1:0] bus_data,
  input  logic          bus_stop,
  output logic          irq
);
  logic          go, clr, busy, done;
  logic [AW-1:0] cfg_start, cur_addr;
  logic [CW-1:0] cfg_len, remain;

  bdma_regs #(.DW(DW), .AW(AW), .CW(CW)) u_regs (
    .clk(clk), .rst(rst),
    .reg_xfer(reg_xfer), .reg_dir(reg_dir), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .busy(busy), .done(done), .remain(remain), .cur_addr(cur_addr),
    .cfg_start(cfg_start), .cfg_len(cfg_len), .go(go), .clr(clr)
  );

  bdma_master #(.AW(AW), .CW(CW)) u_mst (
    .clk(clk), .rst(rst), .go(go), .clr(clr),
    .cfg_start(cfg_start), .cfg_len(cfg_len),
    .bus_gnt(bus_gnt), .bus_stop(bus_stop),
    .bus_req(bus_req), .bus_start(bus_start), .bus_addr(bus_addr),
    .bus_valid(bus_valid), .src_pop(src_pop),
    .busy(busy), .done(done), .remain(remain), .cur_addr(cur_addr)
  );

  assign bus_data = src_data;
  assign irq      = done;
endmodule

// File: rtl/burst_dma_wr_chk.sv
module burst_dma_wr_chk #(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          bus_req,
  input logic          bus_gnt,
  input logic          bus_start,
  input logic          bus_valid,
  input logic          bus_stop,
  input logic          irq,
  input logic          busy,
  input logic [CW-1:0] remain
);
  AST_GNT_COVERS_DRIVE: assert property (@(posedge clk) disable iff (rst)
    (bus_start || bus_valid) |-> bus_gnt);  // R7
  AST_ADDR_THEN_DATA: assert property (@(posedge clk) disable iff (rst)
    bus_start |=> (!bus_start && bus_valid));  // R4
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst)
    (bus_valid && !bus_stop) |=> (remain == $past(remain) - CW'(1)));  // R5
  AST_STOP_RELEASE: assert property (@(posedge clk) disable iff (rst)
    (bus_valid && bus_stop) |=> (!bus_req && !bus_valid && $stable(remain)));  // R6
  AST_STOP_RETRY: assert property (@(posedge clk) disable iff (rst)
    (bus_valid && bus_stop) |=> ##1 bus_req);  // R6
  AST_LAST_DROPS_REQ: assert property (@(posedge clk) disable iff (rst)
    (bus_valid && !bus_stop && remain == CW'(1)) |=> (!bus_req && irq));  // R8
  AST_IDLE_NO_REQ: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !bus_req);  // R7
endmodule

bind burst_dma_wr burst_dma_wr_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst(rst), .bus_req(bus_req), .bus_gnt(bus_gnt),
  .bus_start(bus_start), .bus_valid(bus_valid), .bus_stop(bus_stop),
  .irq(irq), .busy(busy), .remain(remain)
);

// File: tb/sim_burst_dma_wr.sv
`timescale 1ns/1ps
module sim_burst_dma_wr;
  localparam int DW = 32;
  localparam int AW = 32;
  localparam int CW = 16;
  localparam logic [31:0] NO_STOP = 32'hFFFF_FFFF;
  localparam logic [31:0] PAT = 32'hA500_0000;

  // {start, length, grant delay, stop at beat}
  localparam int NV = 4;
  localparam logic [127:0] VEC [NV] = '{
    {32'h0000_1000, 32'd4, 32'd0, NO_STOP},
    {32'h2000_00F0, 32'd9, 32'd2, 32'd3},
    {32'h0000_0FFE, 32'd1, 32'd1, NO_STOP},
    {32'h0000_3000, 32'd6, 32'd3, 32'd0}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic reg_xfer = 1'b0, reg_dir = 1'b0;
  logic [1:0] reg_addr = '0;
  logic [DW-1:0] reg_wdata = '0;
  logic [DW-1:0] reg_rdata;
  logic [DW-1:0] src_data = PAT;
  logic src_pop, bus_req, bus_start, bus_valid, irq;
  logic bus_gnt = 1'b0, bus_stop = 1'b0;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_data;

  always #5 clk = ~clk;

  burst_dma_wr #(.DW(DW), .AW(AW), .CW(CW)) u0 (
    .clk(clk), .rst(rst), .reg_xfer(reg_xfer), .reg_dir(reg_dir),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .src_data(src_data), .src_pop(src_pop), .bus_req(bus_req),
    .bus_gnt(bus_gnt), .bus_start(bus_start), .bus_addr(bus_addr),
    .bus_valid(bus_valid), .bus_data(bus_data), .bus_stop(bus_stop),
    .irq(irq)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int gnt_delay = 0;
  int gcnt = 0;
  logic [31:0] stop_at = NO_STOP;
  logic stopped = 1'b0;
  logic [31:0] acc = 0;
  logic [31:0] pops = 0;
  logic [31:0] total = 0;
  logic [31:0] starts = 0;
  logic [31:0] exp_start = 0;
  logic [31:0] rd;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (!rst && src_pop) pops++;
    if (cyc > 100000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  // bus target and arbiter model
  always @(negedge clk) begin
    if (!rst) begin
      if ((bus_start || bus_valid) && !bus_gnt)
        chk(1'b0, "R7 drive without grant", 32'(bus_valid), 32'd0);
      if (bus_start) begin
        starts++;
        chk(bus_addr == exp_start + acc, "R4 address phase", bus_addr, exp_start + acc);
      end
      if (bus_valid && acc == stop_at && !stopped) begin
        bus_stop = 1'b1;
        stopped  = 1'b1;
      end else begin
        bus_stop = 1'b0;
      end
      if (bus_valid && !bus_stop) begin
        chk(bus_data == PAT + total, "R5 data word", bus_data, PAT + total);
        acc++;
        total++;
        src_data = PAT + total;
      end
      if (!bus_req) begin
        bus_gnt = 1'b0;
        gcnt = 0;
      end else if (!bus_gnt) begin
        if (gcnt >= gnt_delay) bus_gnt = 1'b1;
        else gcnt++;
      end
    end
  end

  task automatic reg_wr(input logic [1:0] a, input logic [31:0] d);
    reg_xfer = 1'b1; reg_dir = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_xfer = 1'b0; reg_dir = 1'b0;
  endtask

  task automatic reg_rd(input logic [1:0] a, output logic [31:0] d);
    reg_xfer = 1'b1; reg_dir = 1'b0; reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
    reg_xfer = 1'b0;
  endtask

  task automatic arm(input logic [31:0] s, input int dly, input logic [31:0] sa);
    gnt_delay = dly; stop_at = sa; stopped = 1'b0;
    acc = 0; pops = 0; starts = 0; exp_start = s;
  endtask

  task automatic wait_irq();
    for (int i = 0; i < 2000 && !irq; i++) @(negedge clk);
  endtask

  task automatic finish_checks(input logic [31:0] s, input logic [31:0] n);
    chk(irq == 1'b1, "R8 irq", 32'(irq), 32'd1);
    chk(acc == n, "R5 words accepted", acc, n);
    chk(pops == n, "R5 source pops", pops, n);
    reg_rd(2'd2, rd);
    chk(rd == 32'h2, "R8 status done", rd, 32'h2);
    reg_rd(2'd3, rd);
    chk(rd == s + n, "R5 current address", rd, s + n);
    reg_wr(2'd2, 32'h2);
    chk(irq == 1'b0, "R9 irq cleared", 32'(irq), 32'd0);
    reg_rd(2'd2, rd);
    chk(rd == 32'h0, "R9 status cleared", rd, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(bus_req == 0 && bus_start == 0 && bus_valid == 0, "R1 bus idle",
        {29'd0, bus_req, bus_start, bus_valid}, 32'd0);
    chk(irq == 0, "R1 irq", 32'(irq), 32'd0);
    reg_rd(2'd2, rd);
    chk(rd == 0, "R1 status", rd, 32'd0);

    // R2 readback
    reg_wr(2'd0, 32'hDEAD_BEE0);
    reg_wr(2'd1, 32'd5);
    reg_rd(2'd0, rd);
    chk(rd == 32'hDEAD_BEE0, "R2 start readback", rd, 32'hDEAD_BEE0);
    reg_rd(2'd1, rd);
    chk(rd == 32'd5, "R2 length readback", rd, 32'd5);

    // vector table
    for (int v = 0; v < NV; v++) begin
      logic [31:0] s, n, d, sa;
      {s, n, d, sa} = VEC[v];
      arm(s, int'(d), sa);
      reg_wr(2'd0, s);
      reg_wr(2'd1, n);
      reg_wr(2'd2, 32'h1);
      chk(bus_req == 1'b1, "R3 request after go", 32'(bus_req), 32'd1);
      reg_rd(2'd2, rd);
      chk(rd[0] == 1'b1, "R3 busy", rd, 32'h1);
      wait_irq();
      chk(bus_req == 1'b0, "R7 request dropped", 32'(bus_req), 32'd0);
      chk(starts == ((sa < n) ? 32'd2 : 32'd1), "R6 address phases", starts,
          (sa < n) ? 32'd2 : 32'd1);
      finish_checks(s, n);
    end

    // R10 go while busy
    arm(32'h0000_5000, 6, NO_STOP);
    reg_wr(2'd0, 32'h0000_5000);
    reg_wr(2'd1, 32'd8);
    reg_wr(2'd2, 32'h1);
    reg_wr(2'd1, 32'd3);
    reg_wr(2'd2, 32'h1);
    wait_irq();
    chk(acc == 32'd8, "R10 second go ignored", acc, 32'd8);
    finish_checks(32'h0000_5000, 32'd8);

    // R11 zero length
    reg_wr(2'd1, 32'd0);
    reg_wr(2'd2, 32'h1);
    chk(irq == 1'b1, "R11 immediate irq", 32'(irq), 32'd1);
    for (int i = 0; i < 5; i++) begin
      chk(bus_req == 1'b0, "R11 no request", 32'(bus_req), 32'd0);
      @(negedge clk);
    end
    reg_wr(2'd2, 32'h2);
    chk(irq == 1'b0, "R9 irq cleared after zero length", 32'(irq), 32'd0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule